// File: doc/BRIEF.md
# Single-Cycle Prefix Code Decoder

This block turns a serial stream of back-to-back prefix-free codewords into a sequence of 8-bit symbols, one symbol per clock when neither side holds it back. Refill words of 16 bits come from an upstream buffer on a valid/ready handshake and are appended to a 32-bit bit window. Each cycle a combinational lookup inspects the next 16 bits of the window, finds the codeword there and its length, and a shifter removes exactly that many bits before the next cycle. Because the next codeword's position is only known once the current length is decoded, this lookup-and-shift loop closes within one cycle.

Decoded symbols leave through a registered valid/ready port that a downstream zero-run expander can stall. The top bit of each symbol tells that expander whether the byte is a literal or a zero-run count. A 16-bit pattern that matches no codeword sets a sticky error flag. From then on the block produces no further symbols and accepts no refill words until reset.

Top module: `vlc_decoder`

## Requirements
- R1: The codebook has 16 entries. Entry k (0 to 15) is written as k zero bits followed by a single one bit, so its length is k+1. Bit in_data[15] of each refill word is the first bit of the stream.
- R2: The symbol for entry k is {k[0], 3'b000, k[3:0]}. Bit 7 is therefore 1 (zero-run count) for odd k and 0 (literal) for even k.
- R3: The symbols come out in stream order, including codewords that straddle two refill words, under any pattern of refill gaps and output stalls.
- R4: While in_valid and out_ready stay high, one symbol is delivered every clock. This holds for streams of 1-bit codewords and for streams of 16-bit codewords.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_sym keeps its value.
- R6: No symbol is decoded while the window holds fewer than 16 bits. After reset with no refill, out_valid stays low. A single word 16'h8000 yields exactly one symbol (8'h00) and then output stops.
- R7: in_ready is high exactly when the error flag is clear and the window holds at most 16 bits. It is high right after reset and low for one cycle after a word arrives while 15 bits are held.
- R8: When the next 16 bits are all zero, err goes high and stays high. No further symbol is produced and in_ready stays low.
- R9: A synchronous active-high reset empties the window and clears out_valid and err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Refill word offered |
| in_data | input | 16 | Refill word; bit 15 is first in stream order |
| in_ready | output | 1 | Block can take a refill word this cycle |
| out_valid | output | 1 | Decoded symbol present |
| out_sym | output | 8 | Decoded symbol; bit 7 marks a zero-run count |
| out_ready | input | 1 | Downstream expander accepts the symbol |
| err | output | 1 | Sticky invalid-code flag |

## Verification
A refill word can be appended in the same cycle that a codeword is removed from the window. When that happens, the new bits must land directly behind the bits that remain after the shift. The randomized phases keep both handshakes active at independent rates, so appends and removals coincide at every fill level. Codewords that cross a word boundary are checked symbol by symbol against a queue built by encoding the same random symbols in the bench. A second overlap occurs when an output stall coincides with a pending codeword; it is judged by checking that the held symbol stays unchanged and that the next symbol in order follows.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  // Default geometry shared by the decoder modules.
  localparam int DEF_WIN_W   = 32;
  localparam int DEF_IN_W    = 16;
  localparam int DEF_MAX_LEN = 16;
  localparam int DEF_SYM_W   = 8;

  // Meaning of the symbol's top bit for the downstream expander.
  typedef enum logic {
    SYM_LITERAL  = 1'b0,
    SYM_ZERO_RUN = 1'b1
  } sym_kind_e;

  // Odd codebook entries carry zero-run counts, even ones literals.
  function automatic sym_kind_e kind_of_entry(input logic entry_lsb);
    return entry_lsb ? SYM_ZERO_RUN : SYM_LITERAL;
  endfunction
endpackage

// File: rtl/vlc_lookup.sv
module vlc_lookup #(
  parameter int MAX_LEN = vlc_pkg::DEF_MAX_LEN,
  parameter int SYM_W   = vlc_pkg::DEF_SYM_W,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic [MAX_LEN-1:0] bits,
  output logic               hit,
  output logic [LEN_W-1:0]   len,
  output logic [SYM_W-1:0]   sym
);
  logic [IDX_W-1:0] idx;

  // Entry index = number of leading zeros before the first one bit.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (!hit && bits[MAX_LEN-1-i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    len                = LEN_W'(idx) + LEN_W'(1);
    sym                = '0;
    sym[IDX_W-1:0]     = idx;
    sym[SYM_W-1]       = vlc_pkg::kind_of_entry(idx[0]);
  end
endmodule

// File: rtl/vlc_window.sv
module vlc_window #(
  parameter int WIN_W   = vlc_pkg::DEF_WIN_W,
  parameter int IN_W    = vlc_pkg::DEF_IN_W,
  parameter int MAX_LEN = vlc_pkg::DEF_MAX_LEN,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = $clog2(WIN_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               consume,
  input  logic [LEN_W-1:0]   consume_len,
  input  logic               halt,
  input  logic               in_valid,
  input  logic [IN_W-1:0]    in_data,
  output logic               in_ready,
  output logic [MAX_LEN-1:0] head,
  output logic               have_code,
  output logic [CNT_W-1:0]   fill_o
);
  localparam int REFILL_AT = WIN_W - IN_W;

  logic [WIN_W-1:0] win_q, win_d, incoming;
  logic [CNT_W-1:0] fill_q, fill_d, used, rest;
  logic             accept;

  assign in_ready  = !halt && (fill_q <= CNT_W'(REFILL_AT));
  assign accept    = in_valid && in_ready;
  assign have_code = fill_q >= CNT_W'(MAX_LEN);
  assign head      = win_q[WIN_W-1 -: MAX_LEN];
  assign fill_o    = fill_q;

  // Window is MSB-aligned; unused low bits are kept at zero.
  always_comb begin
    used     = consume ? CNT_W'(consume_len) : '0;
    rest     = fill_q - used;
    incoming = (WIN_W'(in_data) << REFILL_AT) >> rest;
    win_d    = win_q << used;
    if (accept) win_d = win_d | incoming;
    fill_d   = rest + (accept ? CNT_W'(IN_W) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/vlc_out_stage.sv
module vlc_out_stage #(
  parameter int SYM_W = vlc_pkg::DEF_SYM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SYM_W-1:0] load_sym,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_sym,
  output logic             slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_sym   <= load_sym;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vlc_decoder.sv
module vlc_decoder #(
  parameter int WIN_W   = vlc_pkg::DEF_WIN_W,
  parameter int IN_W    = vlc_pkg::DEF_IN_W,
  parameter int MAX_LEN = vlc_pkg::DEF_MAX_LEN,
  parameter int SYM_W   = vlc_pkg::DEF_SYM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_sym,
  input  logic             out_ready,
  output logic             err
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int CNT_W = $clog2(WIN_W + 1);

  logic [MAX_LEN-1:0] head;
  logic               have_code, hit, slot_free, fire, bad, err_q;
  logic [LEN_W-1:0]   len;
  logic [SYM_W-1:0]   sym;
  logic [CNT_W-1:0]   fill;

  vlc_window #(.WIN_W(WIN_W), .IN_W(IN_W), .MAX_LEN(MAX_LEN)) u_window (
    .clk(clk), .rst(rst), .consume(fire), .consume_len(len), .halt(err_q),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .head(head), .have_code(have_code), .fill_o(fill)
  );

  vlc_lookup #(.MAX_LEN(MAX_LEN), .SYM_W(SYM_W)) u_lookup (
    .bits(head), .hit(hit), .len(len), .sym(sym)
  );

  vlc_out_stage #(.SYM_W(SYM_W)) u_out (
    .clk(clk), .rst(rst), .load(fire), .load_sym(sym), .out_ready(out_ready),
    .out_valid(out_valid), .out_sym(out_sym), .slot_free(slot_free)
  );

  // Decode only with a full code's worth of bits, a free slot and no error.
  assign fire = have_code && !err_q && hit && slot_free;
  assign bad  = have_code && !err_q && !hit;
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (rst)      err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end
endmodule

// File: rtl/vlc_decoder_chk.sv
module vlc_decoder_chk #(
  parameter int WIN_W   = vlc_pkg::DEF_WIN_W,
  parameter int IN_W    = vlc_pkg::DEF_IN_W,
  parameter int MAX_LEN = vlc_pkg::DEF_MAX_LEN,
  parameter int SYM_W   = vlc_pkg::DEF_SYM_W,
  parameter int CNT_W   = $clog2(WIN_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SYM_W-1:0] out_sym,
  input logic             err,
  input logic [CNT_W-1:0] fill
);
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sym));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err && !out_valid |=> !out_valid);

  // R7
  err_no_refill_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !in_ready);

  // R7
  refill_lands_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> fill >= CNT_W'(IN_W) && fill <= CNT_W'(WIN_W));

  // R6
  enough_bits_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(fill) >= CNT_W'(MAX_LEN));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !err && fill == '0);
endmodule

bind vlc_decoder vlc_decoder_chk #(
  .WIN_W(WIN_W), .IN_W(IN_W), .MAX_LEN(MAX_LEN), .SYM_W(SYM_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
  .err(err), .fill(fill)
);

// File: tb/tb_vlc_decoder.sv
module tb_vlc_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_sym;
  logic        out_ready = 1'b0;
  logic        err;

  always #10 clk = ~clk;

  vlc_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sym(out_sym),
    .out_ready(out_ready), .err(err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, hs_cnt = 0;
  bit reported = 0, stalled = 0, took_word = 0, got_sym = 0;
  logic [7:0]  last_sym, stall_sym;
  logic [15:0] wq[$];
  logic [7:0]  exq[$];
  bit          bq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [7:0] ref_sym(input int k);
    logic [3:0] e = 4'(k);
    return {e[0], 3'b000, e};
  endfunction

  // Encoder: entry k = k zeros then a one; pad to whole words with 1-bit codes.
  task automatic build(input int n, input int mode);
    bq.delete(); exq.delete(); wq.delete();
    for (int s = 0; s < n; s++) begin
      int k = (mode == 0) ? int'($urandom_range(15, 0)) : (mode == 1 ? 0 : 15);
      for (int z = 0; z < k; z++) bq.push_back(1'b0);
      bq.push_back(1'b1);
      exq.push_back(ref_sym(k));
    end
    while (bq.size() % 16 != 0) begin
      bq.push_back(1'b1);
      exq.push_back(8'h00);
    end
    for (int w = 0; w < bq.size() / 16; w++) begin
      logic [15:0] v;
      for (int b = 0; b < 16; b++) v[15-b] = bq[w*16+b];
      wq.push_back(v);
    end
    wq.push_back(16'hFFFF);
  endtask

  task automatic cycle(input bit iv, input logic [15:0] id, input bit ordy);
    @(negedge clk);
    in_valid = iv; in_data = id; out_ready = ordy;
    #1;
    cyc++;
    if (stalled)
      check(out_valid && out_sym == stall_sym, "R5", "held symbol", out_sym, stall_sym);
    stalled   = out_valid && !out_ready;
    stall_sym = out_sym;
    took_word = in_valid && in_ready;
    got_sym   = out_valid && out_ready;
    if (got_sym) begin
      hs_cnt++;
      last_sym = out_sym;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    stalled = 0;
    #1;
    check(!out_valid, "R9", "out_valid after reset", out_valid, 0);
    check(!err, "R9", "err after reset", err, 0);
    check(in_ready, "R7", "in_ready after reset", in_ready, 1);
  endtask

  task automatic run_phase(input int rp, input int vp, input string req,
                           output int first, output int last);
    int guard = 0;
    first = -1; last = -1;
    while (exq.size() > 0 && guard < 20000) begin
      bit iv = (wq.size() > 0) && ($urandom_range(99, 0) < vp);
      logic [15:0] d = (wq.size() > 0) ? wq[0] : 16'h0;
      bit rd = $urandom_range(99, 0) < rp;
      cycle(iv, d, rd);
      if (took_word) void'(wq.pop_front());
      if (got_sym) begin
        check(out_sym == exq[0], req, "decoded symbol", out_sym, exq[0]);
        void'(exq.pop_front());
        if (first < 0) first = cyc;
        last = cyc;
      end
      guard++;
    end
    check(exq.size() == 0, req, "symbols left undecoded", exq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int f, l, n;
    do_reset();

    // R6: starved window yields nothing, one word yields one symbol.
    for (int i = 0; i < 5; i++) begin
      cycle(1'b0, 16'h0, 1'b1);
      check(!out_valid, "R6", "out_valid while empty", out_valid, 0);
    end
    cycle(1'b1, 16'h8000, 1'b1);
    check(took_word, "R7", "word accepted when empty", took_word, 1);
    hs_cnt = 0;
    repeat (4) cycle(1'b0, 16'h0, 1'b1);
    check(hs_cnt == 1, "R6", "symbols from one word", hs_cnt, 1);
    check(last_sym == 8'h00, "R1 R2", "entry 0 symbol", last_sym, 8'h00);
    check(in_ready, "R7", "in_ready with 15 bits", in_ready, 1);
    cycle(1'b1, 16'h8000, 1'b1);
    check(took_word, "R7", "word accepted at 15 bits", took_word, 1);
    cycle(1'b0, 16'h0, 1'b1);
    check(!in_ready, "R7", "in_ready with 31 bits", in_ready, 0);
    hs_cnt = 0;
    repeat (4) cycle(1'b0, 16'h0, 1'b1);
    check(hs_cnt == 1, "R6", "symbols across boundary", hs_cnt, 1);
    check(last_sym == 8'h8F, "R2", "entry 15 zero-run symbol", last_sym, 8'h8F);

    // R3: random symbols, both handshakes throttled.
    do_reset();
    build(300, 0);
    run_phase(70, 60, "R1 R2 R3", f, l);
    do_reset();
    build(300, 0);
    run_phase(30, 100, "R3 R5", f, l);
    do_reset();
    build(300, 0);
    run_phase(100, 35, "R3", f, l);

    // R4: full rate with 1-bit and 16-bit codewords.
    do_reset();
    build(200, 1);
    n = exq.size();
    run_phase(100, 100, "R4", f, l);
    check(l - f + 1 == n, "R4", "cycles for 1-bit codes", l - f + 1, n);
    do_reset();
    build(40, 2);
    n = exq.size();
    run_phase(100, 100, "R4", f, l);
    check(l - f + 1 == n, "R4", "cycles for 16-bit codes", l - f + 1, n);

    // R8: all-zero head is invalid.
    do_reset();
    cycle(1'b1, 16'h0000, 1'b1);
    cycle(1'b1, 16'hFFFF, 1'b1);
    hs_cnt = 0;
    repeat (6) cycle(1'b0, 16'h0, 1'b1);
    check(err, "R8", "err raised", err, 1);
    check(hs_cnt == 0, "R8", "symbols after error", hs_cnt, 0);
    check(!in_ready, "R8", "in_ready after error", in_ready, 0);
    cycle(1'b1, 16'h8000, 1'b1);
    check(!took_word, "R8", "word taken after error", took_word, 0);
    repeat (3) cycle(1'b0, 16'h0, 1'b1);
    check(err && hs_cnt == 0, "R8", "error sticky and silent", err, 1);

    do_reset();
    report();
  end
endmodule